// File: doc/BRIEF.md
# Asynchronous Strobe Bus Target for an XY Pixel Writer

This block is the target side of an asynchronous parallel bus. The bus has a 16-bit address, 32-bit data, a data strobe and a read/not-write line. The two top address bits select the board. The remaining address bits pick one of four locations: a start-delay holding register, an end-delay holding register, a combined XY position register and a read-only status word. A single write to the XY location delivers both deflection levels. It also starts a pixel draw in the clock domain.

Address, data and direction are registered on the falling edge of the strobe, which is the end of the bus cycle. The strobe level then passes through a flip-flop synchronizer into the board clock domain. A falling-edge detector turns each completed bus cycle into exactly one internal event. That event updates the selected holding register and issues a one-cycle write strobe or pixel-start pulse. Reads return the sequencer status, registered once in the clock domain, while the strobe is active.

Top module: `xy_strobe_slave`

## Requirements
- R1: While rst_ni is low, and after it is released, x_o, y_o, start_val_o and end_val_o are 0. start_wr_o, end_wr_o and pix_start_o stay low until a bus write completes.
- R2: The block responds only when address bits 15 and 14 are both 0. Writes with any other value in these bits change no output and pulse nothing, and reads with any other value return 0.
- R3: A write to offset 2 (address bits 13..0) sets x_o to data bits 31..16 and y_o to data bits 15..0. Both update in the same cycle as the pix_start_o pulse and are otherwise stable.
- R4: Each completed write to offset 2 gives exactly one pix_start_o pulse, one clock long. With the default two-stage synchronizer, the pulse is high after the third rising clock edge following the strobe falling.
- R5: A write to offset 0 loads start_val_o from data bits 3..0 and gives exactly one start_wr_o pulse, with the same latency as R4.
- R6: A write to offset 1 loads end_val_o from data bits 7..0 and gives exactly one end_wr_o pulse, with the same latency as R4.
- R7: While the strobe is high with bus_rnw_i high and the board is selected at offset 3, bus_rdata_o is {29'b0, end_done_i, start_done_i, busy_i}, each sampled one clock earlier. At all other times bus_rdata_o is 0.
- R8: Reads, writes to offset 3, and writes to offsets 4 and above change no output and pulse nothing.
- R9: Changes on the address, data or direction lines after the strobe has fallen do not affect the values loaded by that bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Board clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 16 | Bus address; bits 15..14 select the board |
| bus_data_i | input | 32 | Bus write data |
| bus_rnw_i | input | 1 | 1 for read, 0 for write |
| bus_strb_i | input | 1 | Data strobe, high during a cycle, asynchronous |
| bus_rdata_o | output | 32 | Read data, 0 unless a status read is active |
| busy_i | input | 1 | Sequencer busy flag |
| start_done_i | input | 1 | Sequencer start-delay done flag |
| end_done_i | input | 1 | Sequencer end-delay done flag |
| x_o | output | 16 | Latched X level |
| y_o | output | 16 | Latched Y level |
| start_val_o | output | 4 | Start-delay holding register |
| end_val_o | output | 8 | End-delay holding register |
| start_wr_o | output | 1 | One-cycle pulse on a start-delay write |
| end_wr_o | output | 1 | One-cycle pulse on an end-delay write |
| pix_start_o | output | 1 | One-cycle pixel-start pulse on an XY write |

## Verification
A stuck or skipped synchronizer stage shows up as a pulse that is late, missing or doubled. It is observable within three clock edges of every write. A capture register that follows the live bus instead of holding would load the scrambled values the bench drives right after the strobe falls, so x_o and y_o would be wrong after the same pulse. Decode errors appear either as a pulse on the wrong strobe or as a nonzero read at an address that should return 0, and both can be seen within one bus cycle.

// File: rtl/xyss_pkg.sv
package xyss_pkg;
  localparam int unsigned SEL_W = 2;

  typedef enum logic [1:0] {
    OFF_START = 2'd0,
    OFF_END   = 2'd1,
    OFF_XY    = 2'd2,
    OFF_STAT  = 2'd3
  } reg_off_e;

  typedef struct packed {
    logic end_done;
    logic start_done;
    logic busy;
  } stat_t;

  localparam int unsigned STAT_W = $bits(stat_t);
endpackage

// File: rtl/xyss_capture.sv
module xyss_capture #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic              strb_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              rnw_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              rnw_o
);
  // bus fields are stable while the strobe is high; hold them from its falling edge
  always_ff @(negedge strb_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      data_o <= '0;
      rnw_o  <= 1'b1;
    end else begin
      addr_o <= addr_i;
      data_o <= data_i;
      rnw_o  <= rnw_i;
    end
  end
endmodule

// File: rtl/xyss_sync.sv
module xyss_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strb_i,
  output logic fall_o
);
  logic [STAGES:0] sh_q;

  genvar g;
  generate
    for (g = 0; g <= STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) sh_q[0] <= 1'b0;
          else         sh_q[0] <= strb_i;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) sh_q[g] <= 1'b0;
          else         sh_q[g] <= sh_q[g-1];
      end
    end
  endgenerate

  assign fall_o = sh_q[STAGES] & ~sh_q[STAGES-1];

  AST_FALL_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o); // R4
endmodule

// File: rtl/xyss_wr_decode.sv
module xyss_wr_decode
  import xyss_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned POS_W   = 16,
  parameter int unsigned START_W = 4,
  parameter int unsigned END_W   = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               evt_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  data_i,
  input  logic               rnw_i,
  output logic [POS_W-1:0]   x_o,
  output logic [POS_W-1:0]   y_o,
  output logic [START_W-1:0] start_val_o,
  output logic [END_W-1:0]   end_val_o,
  output logic               start_wr_o,
  output logic               end_wr_o,
  output logic               pix_start_o
);
  localparam int unsigned OFF_W = ADDR_W - SEL_W;

  logic     sel, mapped, wr_ok;
  reg_off_e kind;

  assign sel    = addr_i[ADDR_W-1 -: SEL_W] == '0;
  assign mapped = addr_i[OFF_W-1:2] == '0;
  assign kind   = reg_off_e'(addr_i[1:0]);
  assign wr_ok  = evt_i & ~rnw_i & sel & mapped;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_o         <= '0;
      y_o         <= '0;
      start_val_o <= '0;
      end_val_o   <= '0;
      start_wr_o  <= 1'b0;
      end_wr_o    <= 1'b0;
      pix_start_o <= 1'b0;
    end else begin
      start_wr_o  <= 1'b0;
      end_wr_o    <= 1'b0;
      pix_start_o <= 1'b0;
      if (wr_ok) begin
        case (kind)
          OFF_START: begin
            start_val_o <= data_i[START_W-1:0];
            start_wr_o  <= 1'b1;
          end
          OFF_END: begin
            end_val_o <= data_i[END_W-1:0];
            end_wr_o  <= 1'b1;
          end
          OFF_XY: begin
            x_o         <= data_i[DATA_W-1 -: POS_W];
            y_o         <= data_i[POS_W-1:0];
            pix_start_o <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({start_wr_o, end_wr_o, pix_start_o})); // R8
  AST_PIX_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_start_o |=> !pix_start_o); // R4
  AST_XY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_start_o |-> $stable({x_o, y_o})); // R3
  AST_START_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_wr_o |-> $stable(start_val_o)); // R5
  AST_END_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !end_wr_o |-> $stable(end_val_o)); // R6
endmodule

// File: rtl/xyss_rd_status.sv
module xyss_rd_status
  import xyss_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  stat_t             stat_i,
  input  logic              strb_i,
  input  logic              rnw_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned OFF_W = ADDR_W - SEL_W;

  stat_t stat_q;
  logic  hit;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= stat_i;

  assign hit = strb_i & rnw_i & (addr_i[ADDR_W-1 -: SEL_W] == '0)
             & (addr_i[OFF_W-1:0] == OFF_W'(OFF_STAT));

  assign rdata_o = hit ? {{(DATA_W-STAT_W){1'b0}}, stat_q} : '0;

  AST_STAT_LAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |-> rdata_o[STAT_W-1:0] == $past(stat_i)); // R7
endmodule

// File: rtl/xy_strobe_slave.sv
module xy_strobe_slave
  import xyss_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned POS_W       = 16,
  parameter int unsigned START_W     = 4,
  parameter int unsigned END_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [DATA_W-1:0]  bus_data_i,
  input  logic               bus_rnw_i,
  input  logic               bus_strb_i,
  output logic [DATA_W-1:0]  bus_rdata_o,
  input  logic               busy_i,
  input  logic               start_done_i,
  input  logic               end_done_i,
  output logic [POS_W-1:0]   x_o,
  output logic [POS_W-1:0]   y_o,
  output logic [START_W-1:0] start_val_o,
  output logic [END_W-1:0]   end_val_o,
  output logic               start_wr_o,
  output logic               end_wr_o,
  output logic               pix_start_o
);
  logic [ADDR_W-1:0] cap_addr;
  logic [DATA_W-1:0] cap_data;
  logic              cap_rnw;
  logic              evt;
  stat_t             stat;

  assign stat = '{end_done: end_done_i, start_done: start_done_i, busy: busy_i};

  xyss_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
    .strb_i (bus_strb_i),
    .rst_ni (rst_ni),
    .addr_i (bus_addr_i),
    .data_i (bus_data_i),
    .rnw_i  (bus_rnw_i),
    .addr_o (cap_addr),
    .data_o (cap_data),
    .rnw_o  (cap_rnw)
  );

  xyss_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .strb_i (bus_strb_i),
    .fall_o (evt)
  );

  xyss_wr_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .POS_W(POS_W),
    .START_W(START_W), .END_W(END_W)
  ) u_wr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .evt_i       (evt),
    .addr_i      (cap_addr),
    .data_i      (cap_data),
    .rnw_i       (cap_rnw),
    .x_o         (x_o),
    .y_o         (y_o),
    .start_val_o (start_val_o),
    .end_val_o   (end_val_o),
    .start_wr_o  (start_wr_o),
    .end_wr_o    (end_wr_o),
    .pix_start_o (pix_start_o)
  );

  xyss_rd_status #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .stat_i  (stat),
    .strb_i  (bus_strb_i),
    .rnw_i   (bus_rnw_i),
    .addr_i  (bus_addr_i),
    .rdata_o (bus_rdata_o)
  );
endmodule

// File: tb/xy_strobe_slave_test.sv
module xy_strobe_slave_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [31:0] data = '0;
  logic        rnw = 1'b1;
  logic        strb = 1'b0;
  logic [31:0] rdata;
  logic        busy = 1'b0, sdone = 1'b0, edone = 1'b0;
  logic [15:0] x, y;
  logic [3:0]  sval;
  logic [7:0]  eval_q;
  logic        swr, ewr, pix;

  int checks = 0;
  int errors = 0;

  logic [15:0] ex_x = '0, ex_y = '0;
  logic [3:0]  ex_s = '0;
  logic [7:0]  ex_e = '0;

  always #4 clk = ~clk;

  xy_strobe_slave uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_data_i(data),
    .bus_rnw_i(rnw), .bus_strb_i(strb), .bus_rdata_o(rdata),
    .busy_i(busy), .start_done_i(sdone), .end_done_i(edone),
    .x_o(x), .y_o(y), .start_val_o(sval), .end_val_o(eval_q),
    .start_wr_o(swr), .end_wr_o(ewr), .pix_start_o(pix)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // 0 none, 1 start, 2 end, 3 xy
  function automatic int wr_kind(input logic [15:0] a);
    if (a[15:14] != 2'b00) return 0;
    case (a[13:0])
      14'd0: return 1;
      14'd1: return 2;
      14'd2: return 3;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] rd_exp(input logic [15:0] a, input logic b, input logic s, input logic e);
    if (a[15:14] == 2'b00 && a[13:0] == 14'd3) return {29'b0, e, s, b};
    return 32'b0;
  endfunction

  task automatic check_outputs(input string req);
    chk(x == ex_x, {req, " x_o"}, 32'(x), 32'(ex_x));
    chk(y == ex_y, {req, " y_o"}, 32'(y), 32'(ex_y));
    chk(sval == ex_s, {req, " start_val_o"}, 32'(sval), 32'(ex_s));
    chk(eval_q == ex_e, {req, " end_val_o"}, 32'(eval_q), 32'(ex_e));
  endtask

  // watch 6 cycles after the strobe falls; expect pulse on rising edge 3 of the chosen kind only
  task automatic observe(input int kind, input string req);
    int n_s = 0, n_e = 0, n_p = 0, at = 0;
    for (int k = 1; k <= 6; k++) begin
      @(posedge clk); #1;
      if (swr) begin n_s++; if (at == 0) at = k; end
      if (ewr) begin n_e++; if (at == 0) at = k; end
      if (pix) begin n_p++; if (at == 0) at = k; end
    end
    chk(n_s == (kind == 1 ? 1 : 0), {req, " start_wr_o count"}, 32'(n_s), 32'(kind == 1));
    chk(n_e == (kind == 2 ? 1 : 0), {req, " end_wr_o count"}, 32'(n_e), 32'(kind == 2));
    chk(n_p == (kind == 3 ? 1 : 0), {req, " pix_start_o count"}, 32'(n_p), 32'(kind == 3));
    if (kind != 0) chk(at == 3, {req, " latency R4"}, 32'(at), 32'd3);
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [31:0] d, input string req);
    int kind;
    kind = wr_kind(a);
    @(negedge clk);
    addr = a; data = d; rnw = 1'b0;
    #1 strb = 1'b1;
    #20 strb = 1'b0;
    #1 addr = 16'($urandom); data = $urandom; rnw = 1'($urandom); // R9 scramble
    case (kind)
      1: ex_s = d[3:0];
      2: ex_e = d[7:0];
      3: begin ex_x = d[31:16]; ex_y = d[15:0]; end
      default: ;
    endcase
    observe(kind, req);
    check_outputs({req, " R9"});
    rnw = 1'b1;
  endtask

  task automatic bus_read(input logic [15:0] a, input string req);
    logic [31:0] exp;
    busy = 1'($urandom); sdone = 1'($urandom); edone = 1'($urandom);
    repeat (2) @(posedge clk);
    exp = rd_exp(a, busy, sdone, edone);
    @(negedge clk);
    addr = a; data = $urandom; rnw = 1'b1;
    #1 strb = 1'b1;
    #2 chk(rdata == exp, {req, " R7 read"}, rdata, exp);
    #10 strb = 1'b0;
    #1 chk(rdata == 32'b0, "R7 idle zero", rdata, 32'b0);
    observe(0, {req, " R8 read no side effect"});
    check_outputs({req, " R8"});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(posedge clk); #1;
    check_outputs("R1 in reset");
    chk({swr, ewr, pix} == 3'b0, "R1 strobes in reset", 32'({swr, ewr, pix}), 32'd0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk); #1;
    check_outputs("R1 after reset");
    chk({swr, ewr, pix} == 3'b0, "R1 strobes after reset", 32'({swr, ewr, pix}), 32'd0);

    bus_write(16'h0002, 32'hFFFF_0000, "R3 xy extreme");
    bus_write(16'h0002, 32'h0000_FFFF, "R3 xy swapped");
    bus_write(16'h0002, 32'h1234_ABCD, "R4 back-to-back xy");
    bus_write(16'h0000, 32'hFFFF_FFF9, "R5 start");
    bus_write(16'h0001, 32'hFFFF_FF5A, "R6 end");
    bus_write(16'h4002, 32'hDEAD_BEEF, "R2 unselected xy");
    bus_write(16'hC000, 32'h0000_000F, "R2 unselected start");
    bus_write(16'h0003, 32'h0000_0007, "R8 status write");
    bus_write(16'h0006, 32'h5555_AAAA, "R8 unmapped write");
    bus_read(16'h0003, "R7 status");
    bus_read(16'h8003, "R2 unselected status");
    bus_read(16'h0002, "R8 read xy offset");

    for (int i = 0; i < 60; i++) begin
      int op;
      logic [15:0] a;
      op = int'($urandom % 6);
      case (op)
        0, 1: a = {2'b00, 12'b0, 2'($urandom % 3)};
        2: a = {2'($urandom % 3 + 1), 14'($urandom)};
        3: a = {2'b00, 14'($urandom % 16380 + 4)};
        default: a = 16'($urandom);
      endcase
      if (op >= 4) bus_read(op == 4 ? 16'h0003 : a, "R7 random read");
      else bus_write(a, $urandom, "R3 random write");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule